// File: doc/BRIEF.md
# Frame-Pattern Word Alignment Controller

This block sits behind a 1:7 serial-to-parallel converter that delivers one 7-bit word per lane whenever its word strobe is high. One lane carries no data. It carries a fixed frame pattern: when the word boundary is right, its words alternate between all ones and all zeros. The controller inspects that frame word and, while it is a mixed pattern, asks the converter to shift its word boundary by one bit. It does this with single-cycle `bitslip` pulses, and after each pulse it lets a few words pass before it looks again. The same slip acts on every lane. A clean frame lane therefore means the data lanes are word-aligned as well, and no search is made on them.

Lock is declared once a run of consecutive frame words is clean and alternates. While locked, the frame value tells the two halves of a 14-bit converter sample apart. An all-ones frame word marks the high seven bits and an all-zeros word marks the low seven bits. Each high/low pair on every data lane is joined into one 14-bit sample, and all lanes share one valid strobe. If the frame pattern breaks while locked, lock is dropped and the search starts again. An error flag shows that the search has used its slip budget without success. The search goes on regardless.

Top module: `frame_word_aligner`

## Requirements
- R1: While reset is held, and in the first cycle after it, `bitslip`, `locked`, `slipError` and `sampleValid` are all low, and `samples` is zero.
- R2: Each slip request makes `bitslip` high for exactly one clock. `bitslip` is never high in two consecutive cycles.
- R3: While searching, a checked valid frame word that is neither 7'b1111111 nor 7'b0000000 causes a slip pulse in the next cycle. After every slip pulse, the next SETTLE_CNT valid words are not evaluated.
- R4: `locked` rises in the cycle after the LOCK_CNT-th consecutive valid frame word that is clean and differs from the frame word before it.
- R5: `bitslip` is never high while `locked` is high.
- R6: While locked, a valid frame word that is mixed, or that equals the previous frame word, clears `locked` and raises `bitslip` together in the next cycle.
- R7: While locked, a valid word with frame 7'b1111111 supplies the high half and the next valid word with frame 7'b0000000 supplies the low half. Lane n's sample is `samples[14n+13:14n]` = {high, low}. `sampleValid` is high for exactly the one cycle after the low word is accepted, and `samples` holds its value in between.
- R8: While locked, a low-half word not directly preceded by a high-half valid word yields no sample.
- R9: `slipError` rises in the cycle after the MAX_SLIPS-th slip since the last lock or reset. It stays high while searching and is low from the first locked cycle.
- R10: In cycles with `wordValid` low, `frameWord` and `dataWords` have no effect, and no settle, lock or pairing progress is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wordValid | input | 1 | A new set of parallel words is present this cycle |
| frameWord | input | WORD_W | Word from the frame-pattern lane |
| dataWords | input | LANES*WORD_W | Data-lane words, lane n at bits [WORD_W*n +: WORD_W] |
| bitslip | output | 1 | One-cycle request to shift the word boundary by one bit |
| locked | output | 1 | Frame pattern is aligned and alternating |
| slipError | output | 1 | Slip budget used up without reaching lock |
| sampleValid | output | 1 | One-cycle strobe for a new set of samples |
| samples | output | LANES*2*WORD_W | Joined samples, lane n at bits [2*WORD_W*n +: 2*WORD_W] |

## Verification
The bench builds the block with four lanes, a settle count of 2, a lock run of 4 and a slip budget of 5. The stream starts one bit off the boundary, so six slips are needed. That overruns the slip budget, which means the error flag is raised and then cleared on the way to lock. The short lock run allows several lock losses and relocks within a short run: one from a corrupted frame word, one from a repeated word, and one from a long stretch of garbage frame pattern. Gapped word strobes, with junk driven on the idle cycles, also exercise the settle counting and the pairing.

// File: rtl/fwa_pkg.sv
package fwa_pkg;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_SLIP,
    ST_SETTLE,
    ST_CHECK,
    ST_LOCKED
  } alignState_t;

  // Datapath -> control: classification of the current frame word
  typedef struct packed {
    logic wordValid;
    logic allOnes;
    logic allZeros;
  } frameStat_t;

  // Control -> datapath strobes
  typedef struct packed {
    logic pairEn;
  } ctrlStrobe_t;

endpackage

// File: rtl/fwa_ctrl.sv
module fwa_ctrl
  import fwa_pkg::*;
#(
  parameter int SETTLE_CNT = 3,
  parameter int LOCK_CNT   = 8,
  parameter int MAX_SLIPS  = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  frameStat_t  frameStat,
  output ctrlStrobe_t ctrlStrobe,
  output logic        bitslip,
  output logic        locked,
  output logic        slipError
);

  localparam int STREAK_W    = $clog2(LOCK_CNT + 2);
  localparam int SETTLE_W    = $clog2(SETTLE_CNT + 2);
  localparam int SLIPCNT_W   = $clog2(MAX_SLIPS + 2);
  localparam int LOCK_LAST   = (LOCK_CNT > 0) ? LOCK_CNT - 1 : 0;
  localparam int SETTLE_LAST = (SETTLE_CNT > 0) ? SETTLE_CNT - 1 : 0;

  alignState_t          state, stateNext;
  logic [STREAK_W-1:0]  streak, streakNext;
  logic [SETTLE_W-1:0]  settle, settleNext;
  logic [SLIPCNT_W-1:0] slipCnt, slipCntNext;
  logic                 prevOnes, prevOnesNext;
  logic                 cleanWord;
  logic                 alternates;

  assign cleanWord  = frameStat.allOnes | frameStat.allZeros;
  assign alternates = cleanWord &&
                      ((streak == '0) || (frameStat.allOnes != prevOnes));

  always_comb begin
    stateNext    = state;
    streakNext   = streak;
    settleNext   = settle;
    slipCntNext  = slipCnt;
    prevOnesNext = prevOnes;
    case (state)
      ST_RESET: begin
        stateNext  = ST_CHECK;
        streakNext = '0;
      end
      ST_CHECK: begin
        if (frameStat.wordValid) begin
          if (alternates) begin
            prevOnesNext = frameStat.allOnes;
            if (streak == STREAK_W'(LOCK_LAST)) begin
              stateNext   = ST_LOCKED;
              streakNext  = '0;
              slipCntNext = '0;
            end else begin
              streakNext = streak + 1'b1;
            end
          end else begin
            stateNext = ST_SLIP;
          end
        end
      end
      ST_SLIP: begin
        if (slipCnt != SLIPCNT_W'(MAX_SLIPS)) slipCntNext = slipCnt + 1'b1;
        streakNext = '0;
        settleNext = '0;
        stateNext  = (SETTLE_CNT == 0) ? ST_CHECK : ST_SETTLE;
      end
      ST_SETTLE: begin
        if (frameStat.wordValid) begin
          if (settle == SETTLE_W'(SETTLE_LAST)) stateNext = ST_CHECK;
          else settleNext = settle + 1'b1;
        end
      end
      ST_LOCKED: begin
        if (frameStat.wordValid) begin
          if (cleanWord && (frameStat.allOnes != prevOnes))
            prevOnesNext = frameStat.allOnes;
          else
            stateNext = ST_SLIP;
        end
      end
      default: stateNext = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_RESET;
      streak   <= '0;
      settle   <= '0;
      slipCnt  <= '0;
      prevOnes <= 1'b0;
    end else begin
      state    <= stateNext;
      streak   <= streakNext;
      settle   <= settleNext;
      slipCnt  <= slipCntNext;
      prevOnes <= prevOnesNext;
    end
  end

  assign bitslip           = (state == ST_SLIP);
  assign locked            = (state == ST_LOCKED);
  assign slipError         = (slipCnt >= SLIPCNT_W'(MAX_SLIPS));
  assign ctrlStrobe.pairEn = (state == ST_LOCKED);

endmodule

// File: rtl/fwa_datapath.sv
module fwa_datapath
  import fwa_pkg::*;
#(
  parameter int WORD_W = 7,
  parameter int LANES  = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wordValid,
  input  logic [WORD_W-1:0]            frameWord,
  input  logic [LANES*WORD_W-1:0]      dataWords,
  input  ctrlStrobe_t                  ctrlStrobe,
  output frameStat_t                   frameStat,
  output logic                         sampleValid,
  output logic [LANES*2*WORD_W-1:0]    samples
);

  localparam int SAMP_W = 2 * WORD_W;

  logic haveHigh;
  logic takeHigh;
  logic emitSample;

  assign frameStat.wordValid = wordValid;
  assign frameStat.allOnes   = &frameWord;
  assign frameStat.allZeros  = ~|frameWord;

  assign takeHigh   = ctrlStrobe.pairEn && wordValid && frameStat.allOnes;
  assign emitSample = ctrlStrobe.pairEn && wordValid && frameStat.allZeros && haveHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haveHigh    <= 1'b0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= emitSample;
      if (!ctrlStrobe.pairEn) haveHigh <= 1'b0;
      else if (wordValid)     haveHigh <= takeHigh;
    end
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [WORD_W-1:0] highHalf;
    logic [SAMP_W-1:0] sampleReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        highHalf  <= '0;
        sampleReg <= '0;
      end else begin
        if (takeHigh)   highHalf  <= dataWords[lane*WORD_W +: WORD_W];
        if (emitSample) sampleReg <= {highHalf, dataWords[lane*WORD_W +: WORD_W]};
      end
    end

    assign samples[lane*SAMP_W +: SAMP_W] = sampleReg;
  end

endmodule

// File: rtl/frame_word_aligner.sv
module frame_word_aligner
  import fwa_pkg::*;
#(
  parameter int WORD_W     = 7,
  parameter int LANES      = 8,
  parameter int SETTLE_CNT = 3,
  parameter int LOCK_CNT   = 8,
  parameter int MAX_SLIPS  = 7
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wordValid,
  input  logic [WORD_W-1:0]         frameWord,
  input  logic [LANES*WORD_W-1:0]   dataWords,
  output logic                      bitslip,
  output logic                      locked,
  output logic                      slipError,
  output logic                      sampleValid,
  output logic [LANES*2*WORD_W-1:0] samples
);

  frameStat_t  frameStat;
  ctrlStrobe_t ctrlStrobe;

  fwa_ctrl #(
    .SETTLE_CNT(SETTLE_CNT),
    .LOCK_CNT  (LOCK_CNT),
    .MAX_SLIPS (MAX_SLIPS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameStat (frameStat),
    .ctrlStrobe(ctrlStrobe),
    .bitslip   (bitslip),
    .locked    (locked),
    .slipError (slipError)
  );

  fwa_datapath #(
    .WORD_W(WORD_W),
    .LANES (LANES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .wordValid  (wordValid),
    .frameWord  (frameWord),
    .dataWords  (dataWords),
    .ctrlStrobe (ctrlStrobe),
    .frameStat  (frameStat),
    .sampleValid(sampleValid),
    .samples    (samples)
  );

endmodule

// File: rtl/fwa_checker.sv
module fwa_checker (
  input logic clk,
  input logic rstN,
  input logic bitslip,
  input logic locked,
  input logic slipError,
  input logic sampleValid
);

  // R2: a slip request never spans two cycles
  p_single_slip_r2: assert property (@(posedge clk) disable iff (!rstN)
    bitslip |=> !bitslip);

  // R5: no slip while locked
  p_quiet_locked_r5: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> !bitslip);

  // R6: losing lock always comes with a slip
  p_drop_slips_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> bitslip);

  // R7: a sample only follows a locked cycle
  p_sample_after_lock_r7: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> $past(locked));

  // R9: error is cleared while locked
  p_error_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> !slipError);

endmodule

bind frame_word_aligner fwa_checker u_fwa_checker (
  .clk        (clk),
  .rstN       (rstN),
  .bitslip    (bitslip),
  .locked     (locked),
  .slipError  (slipError),
  .sampleValid(sampleValid)
);

// File: tb/tb_frame_word_aligner.sv
module tb_frame_word_aligner;

  localparam int W  = 7;
  localparam int LN = 4;
  localparam int ST = 2;
  localparam int LK = 4;
  localparam int MX = 5;
  localparam int SW = 2 * W;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wordValid = 1'b0;
  logic [W-1:0] frameWord = '0;
  logic [LN*W-1:0] dataWords = '0;
  logic bitslip, locked, slipError, sampleValid;
  logic [LN*SW-1:0] samples;

  always #2 clk = ~clk;

  frame_word_aligner #(
    .WORD_W(W), .LANES(LN), .SETTLE_CNT(ST), .LOCK_CNT(LK), .MAX_SLIPS(MX)
  ) dut (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .frameWord(frameWord),
    .dataWords(dataWords), .bitslip(bitslip), .locked(locked),
    .slipError(slipError), .sampleValid(sampleValid), .samples(samples)
  );

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;

  // stimulus controls
  longint pos = 1;
  bit corrupt = 0, dup = 0, garbage = 0, gapMode = 0;
  int unsigned rnd = 32'h1234_5678;

  // behavioural reference: 0 reset, 1 check, 2 slip, 3 settle, 4 locked
  int mst = 0, mStreak = 0, mSettle = 0, mCnt = 0;
  bit mPrev = 0, mHave = 0, mSv = 0, mOrphan = 0, mFromLock = 0, prevValid = 0;
  bit errSeen = 0;
  logic [LN*W-1:0] mHigh = '0;
  logic [LN*SW-1:0] mSamples = '0;

  function automatic logic [SW-1:0] sampleOf(longint k, int lane);
    return SW'(k * 37 + lane * 101 + 5);
  endfunction

  function automatic bit streamBit(longint i, int lane);
    logic [SW-1:0] v;
    if (lane < 0) return (i % 14) < 7;
    v = sampleOf(i / 14, lane);
    return v[13 - int'(i % 14)];
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mst = 0; mStreak = 0; mSettle = 0; mCnt = 0; mPrev = 0;
      mHave = 0; mSv = 0; mOrphan = 0; mFromLock = 0; mHigh = '0; mSamples = '0;
    end else begin
      bit ones, zeros, clean;
      ones = (frameWord == 7'b1111111);
      zeros = (frameWord == 7'b0000000);
      clean = ones || zeros;
      mSv = 0; mOrphan = 0; mFromLock = 0;
      if (mst == 4) begin
        if (wordValid) begin
          if (ones) begin
            mHigh = dataWords; mHave = 1;
          end else if (zeros && mHave) begin
            for (int l = 0; l < LN; l++)
              mSamples[l*SW +: SW] = {mHigh[l*W +: W], dataWords[l*W +: W]};
            mSv = 1; mHave = 0;
          end else begin
            if (zeros) mOrphan = 1;
            mHave = 0;
          end
        end
      end else begin
        mHave = 0;
      end
      case (mst)
        0: begin mst = 1; mStreak = 0; end
        1: if (wordValid) begin
             if (clean && (mStreak == 0 || ones != mPrev)) begin
               mPrev = ones;
               if (mStreak == LK - 1) begin mst = 4; mStreak = 0; mCnt = 0; end
               else mStreak++;
             end else mst = 2;
           end
        2: begin
             if (mCnt < MX) mCnt++;
             mStreak = 0; mSettle = 0;
             mst = (ST == 0) ? 1 : 3;
           end
        3: if (wordValid) begin
             if (mSettle == ST - 1) mst = 1;
             else mSettle++;
           end
        default: if (wordValid) begin
             if (clean && ones != mPrev) mPrev = ones;
             else begin mst = 2; mFromLock = 1; end
           end
      endcase
      if (mCnt >= MX) errSeen = 1;
    end
  end

  // compare outputs, then drive next inputs, on falling edges
  always @(negedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
    if (rstN) begin
      chk((mst == 2) ? "R2" : "R3", bitslip, (mst == 2));
      chk(mFromLock ? "R6" : "R4", locked, (mst == 4));
      chk("R9", slipError, (mCnt >= MX));
      chk("R5", locked && bitslip, 0);
      chk(mOrphan ? "R8" : (!prevValid ? "R10" : "R7"), sampleValid, mSv);
      chk("R7", samples, mSamples);
    end
    prevValid = wordValid;
    if (bitslip) pos++;
    rnd = rnd * 1103515245 + 12345;
    if (!gapMode || rnd[16]) begin
      for (int b = 0; b < W; b++) begin
        frameWord[W-1-b] = streamBit(pos + b, -1);
        for (int l = 0; l < LN; l++)
          dataWords[l*W + W-1-b] = streamBit(pos + b, l);
      end
      if (garbage) frameWord = 7'b1010101;
      if (corrupt) begin frameWord = 7'b0011100; corrupt = 0; end
      if (dup) dup = 0;
      else pos += W;
      wordValid = 1'b1;
    end else begin
      wordValid = 1'b0;
      frameWord = 7'b0110110;
      dataWords = {LN{7'b1011001}};
    end
  end

  task automatic waitLock();
    int n = 0;
    while (!locked && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk("R4", locked, 1);
  endtask

  initial begin
    rstN = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk("R1", {bitslip, locked, slipError, sampleValid}, 0);
      chk("R1", samples, 0);
    end
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", {bitslip, locked, slipError, sampleValid}, 0);
    waitLock();
    chk("R9", errSeen, 1);
    repeat (40) @(negedge clk);
    gapMode = 1;
    repeat (80) @(negedge clk);
    gapMode = 0;
    corrupt = 1;
    repeat (4) @(negedge clk);
    chk("R6", locked, 0);
    waitLock();
    repeat (20) @(negedge clk);
    dup = 1;
    repeat (4) @(negedge clk);
    chk("R6", locked, 0);
    waitLock();
    repeat (20) @(negedge clk);
    garbage = 1;
    repeat (150) @(negedge clk);
    chk("R9", slipError, 1);
    chk("R3", locked, 0);
    garbage = 0;
    waitLock();
    gapMode = 1;
    repeat (60) @(negedge clk);
    gapMode = 0;
    repeat (20) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule